// File: doc/BRIEF.md
# Big-Endian Word-Bus Access Sequencer

This block sits between a load/store requester and a 16-bit data bus that has separate strobes for its upper and lower byte lanes. A requester presents a byte address, a transfer size, a direction and up to 32 bits of write data under a valid/ready handshake. The sequencer turns each request into one or two bus cycles and waits for an acknowledge on each. It returns a single-cycle response that carries the assembled read data or an address-error flag.

Byte order is big-endian. A word's address is the address of its more significant byte, and the less significant byte lives at the next odd address. Word and long-word transfers must start on an even address. A long word at address n is carried as two word cycles: the word at n holds bits 31:16 and goes first, then the word at n+2 holds bits 15:0. A request that breaks the alignment rule, or that uses the reserved size code, is answered with an error and never reaches the bus.

Top module: `be_bus_seq`

## Requirements
- R1: Size code 2'b00 is a byte. A byte access at an even address asserts only `bus_ustb`, drives the write byte on `bus_wdata[15:8]`, and returns `bus_rdata[15:8]` zero-extended in `rsp_rdata[7:0]`.
- R2: A byte access at an odd address asserts only `bus_lstb`, drives the write byte on `bus_wdata[7:0]`, returns `bus_rdata[7:0]` zero-extended, and raises no error.
- R3: Size code 2'b01 is a word. A word access at an even address takes exactly one bus cycle with both strobes asserted. It writes `req_wdata[15:0]` and returns the bus word in `rsp_rdata[15:0]`, with the upper half zero.
- R4: Size code 2'b10 is a long word. A long word at even address n takes exactly two bus cycles, at n and then n+2. The first cycle carries bits 31:16 and the second carries bits 15:0, in both directions.
- R5: A word or long-word request at an odd address produces a response with `rsp_err` high and `rsp_rdata` zero, and no bus cycle is issued.
- R6: The reserved size code 2'b11 produces an error response with no bus cycle at any address.
- R7: While `bus_cyc` is high and `bus_ack` is low, the bus address, strobes, direction and write data hold steady into the next cycle.
- R8: `req_ready` is low from the cycle after a request is accepted until the response has been given, so at most one request is in flight.
- R9: After reset, `req_ready` is high and `bus_cyc`, both strobes and `rsp_valid` are low.
- R10: `bus_addr` is always even while `bus_cyc` is high; the strobes alone select the byte lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | 00 byte, 01 word, 10 long, 11 reserved |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Address error |
| rsp_rdata | output | 32 | Load data, right-aligned and zero-extended |
| bus_cyc | output | 1 | Bus cycle active |
| bus_addr | output | ADDR_W | Even word address of the cycle |
| bus_we | output | 1 | Bus cycle is a write |
| bus_ustb | output | 1 | Upper byte lane (15:8) strobe |
| bus_lstb | output | 1 | Lower byte lane (7:0) strobe |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid with acknowledge |
| bus_ack | input | 1 | Bus cycle acknowledge |

## Verification
The bench targets four groups of cases, and each names the fault it would expose:
- **Lane choice for a byte at an even versus an odd address.** A design with swapped lanes strobes the wrong half and returns the neighbouring byte.
- **Long-word ordering.** If the halves are swapped or the second address is wrong, the logged cycles do not show bits 31:16 at n followed by bits 15:0 at n+2.
- **Multibyte requests at odd addresses and the reserved size code.** A design that skips the alignment check issues a bus cycle or reports no error.
- **Wait states, and ready during a transfer.** These catch a sequencer that moves on before the acknowledge or accepts a second request too early.

// File: rtl/be_bus_pkg.sv
package be_bus_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CYC1,
        ST_CYC2,
        ST_RESP
    } seq_state_e;

endpackage

// File: rtl/be_align_chk.sv
module be_align_chk
    import be_bus_pkg::*;
(
    input  xfer_size_e size,
    input  logic       addr_lsb,
    output logic       fault
);
    always_comb begin
        fault = 1'b0;
        if (size == SZ_RSVD) begin
            fault = 1'b1;
        end else if (size != SZ_BYTE && addr_lsb) begin
            fault = 1'b1;
        end
    end
endmodule

// File: rtl/be_lane_sel.sv
module be_lane_sel
    import be_bus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 16
) (
    input  xfer_size_e          size,
    input  logic                addr_lsb,
    input  logic                second_half,
    input  logic [DATA_W-1:0]   wdata,
    output logic                ustb,
    output logic                lstb,
    output logic [LANE_W-1:0]   wlane
);
    localparam int BYTE_W = LANE_W / 2;

    always_comb begin
        ustb  = 1'b0;
        lstb  = 1'b0;
        wlane = '0;
        case (size)
            SZ_BYTE: begin
                ustb  = !addr_lsb;
                lstb  = addr_lsb;
                wlane = {wdata[BYTE_W-1:0], wdata[BYTE_W-1:0]};
            end
            SZ_WORD: begin
                ustb  = 1'b1;
                lstb  = 1'b1;
                wlane = wdata[LANE_W-1:0];
            end
            SZ_LONG: begin
                ustb  = 1'b1;
                lstb  = 1'b1;
                wlane = second_half ? wdata[LANE_W-1:0] : wdata[DATA_W-1:LANE_W];
            end
            default: begin
                ustb  = 1'b0;
                lstb  = 1'b0;
                wlane = '0;
            end
        endcase
    end
endmodule

// File: rtl/be_rd_merge.sv
module be_rd_merge
    import be_bus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 16
) (
    input  xfer_size_e          size,
    input  logic                addr_lsb,
    input  logic [LANE_W-1:0]   hi_word,
    input  logic [LANE_W-1:0]   bus_word,
    output logic [DATA_W-1:0]   rdata
);
    localparam int BYTE_W = LANE_W / 2;

    always_comb begin
        rdata = '0;
        case (size)
            SZ_BYTE: rdata[BYTE_W-1:0] = addr_lsb ? bus_word[BYTE_W-1:0]
                                                  : bus_word[LANE_W-1:BYTE_W];
            SZ_WORD: rdata[LANE_W-1:0] = bus_word;
            SZ_LONG: rdata = {hi_word, bus_word};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/be_bus_seq.sv
module be_bus_seq
    import be_bus_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              bus_cyc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic              bus_ustb,
    output logic              bus_lstb,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    input  logic              bus_ack
);
    localparam int DATA_W = 32;
    localparam int LANE_W = 16;
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(LANE_W / 8);

    typedef struct packed {
        seq_state_e          state;
        logic [ADDR_W-1:0]   addr;
        xfer_size_e          size;
        logic                lsb;
        logic                write;
        logic [DATA_W-1:0]   wdata;
        logic [LANE_W-1:0]   hi;
        logic                err;
        logic [DATA_W-1:0]   rdata;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    xfer_size_e            in_size;
    logic                  in_fault;
    logic                  lane_u, lane_l;
    logic [LANE_W-1:0]     lane_wd;
    logic [DATA_W-1:0]     merged;

    assign in_size = xfer_size_e'(req_size);

    be_align_chk u_align (
        .size     (in_size),
        .addr_lsb (req_addr[0]),
        .fault    (in_fault)
    );

    be_lane_sel #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lane (
        .size        (r_q.size),
        .addr_lsb    (r_q.lsb),
        .second_half (r_q.state == ST_CYC2),
        .wdata       (r_q.wdata),
        .ustb        (lane_u),
        .lstb        (lane_l),
        .wlane       (lane_wd)
    );

    be_rd_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_merge (
        .size     (r_q.size),
        .addr_lsb (r_q.lsb),
        .hi_word  (r_q.hi),
        .bus_word (bus_rdata),
        .rdata    (merged)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (in_fault) begin
                        r_d.state = ST_RESP;
                        r_d.err   = 1'b1;
                        r_d.rdata = '0;
                    end else begin
                        r_d.state = ST_CYC1;
                        r_d.addr  = {req_addr[ADDR_W-1:1], 1'b0};
                        r_d.size  = in_size;
                        r_d.lsb   = req_addr[0];
                        r_d.write = req_write;
                        r_d.wdata = req_wdata;
                        r_d.err   = 1'b0;
                    end
                end
            end
            ST_CYC1: begin
                if (bus_ack) begin
                    if (r_q.size == SZ_LONG) begin
                        r_d.hi    = bus_rdata;
                        r_d.addr  = r_q.addr + WORD_STEP;
                        r_d.state = ST_CYC2;
                    end else begin
                        r_d.rdata = r_q.write ? '0 : merged;
                        r_d.state = ST_RESP;
                    end
                end
            end
            ST_CYC2: begin
                if (bus_ack) begin
                    r_d.rdata = r_q.write ? '0 : merged;
                    r_d.state = ST_RESP;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, size: SZ_BYTE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign bus_cyc   = (r_q.state == ST_CYC1) || (r_q.state == ST_CYC2);
    assign bus_addr  = r_q.addr;
    assign bus_we    = bus_cyc && r_q.write;
    assign bus_ustb  = bus_cyc && lane_u;
    assign bus_lstb  = bus_cyc && lane_l;
    assign bus_wdata = lane_wd;
    assign rsp_valid = (r_q.state == ST_RESP);
    assign rsp_err   = r_q.err;
    assign rsp_rdata = r_q.rdata;

endmodule

// File: rtl/be_bus_seq_chk.sv
module be_bus_seq_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              bus_cyc,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_ustb,
    input logic              bus_lstb,
    input logic [15:0]       bus_wdata,
    input logic              bus_ack
);
    // R7: a stalled cycle keeps every bus output steady
    p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && !bus_ack |=> bus_cyc && $stable(bus_addr) && $stable(bus_ustb)
                                && $stable(bus_lstb) && $stable(bus_we) && $stable(bus_wdata));

    // R8: no new request can be accepted while a bus cycle or response is pending
    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc || rsp_valid) |-> !req_ready);

    // R8: the response is followed by readiness
    p_ready_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R10: bus address even during a cycle
    p_even_bus_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> !bus_addr[0]);

    // R1: a live cycle has at least one lane, an idle bus none
    p_strobe_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc ? (bus_ustb || bus_lstb) : !(bus_ustb || bus_lstb));

    // R4: a cycle that follows straight on from an acknowledged one is two bytes further on
    p_second_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && bus_ack |=> !bus_cyc || (bus_addr == $past(bus_addr) + ADDR_W'(2)));

    // R5: an error is reported only with a response
    p_err_with_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err && !bus_cyc && !req_ready) |-> rsp_valid);
endmodule

bind be_bus_seq be_bus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .bus_cyc   (bus_cyc),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_ustb  (bus_ustb),
    .bus_lstb  (bus_lstb),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/be_bus_seq_tb.sv
module be_bus_seq_tb;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'b00;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, rsp_err;
    logic [31:0]   rsp_rdata;
    logic          bus_cyc, bus_we, bus_ustb, bus_lstb;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata;
    logic [15:0]   bus_rdata = '0;
    logic          bus_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    be_bus_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_ustb(bus_ustb), .bus_lstb(bus_lstb), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] mem_rd(input logic [AW-1:0] a);
        return {a[8:1] ^ 8'h5A, a[7:0] ^ 8'hC3};
    endfunction

    // bus responder with programmable wait states; logs each acknowledged cycle
    int            ws = 0;
    int            wcnt = 0;
    int            logn = 0;
    int            cyc_cnt = 0;
    logic [AW-1:0] lg_addr [256];
    logic          lg_u [256];
    logic          lg_l [256];
    logic          lg_we [256];
    logic [15:0]   lg_wd [256];

    always @(negedge clk) begin
        if (bus_cyc) begin
            cyc_cnt++;
            if (wcnt >= ws) begin
                bus_ack   = 1'b1;
                bus_rdata = mem_rd(bus_addr);
                lg_addr[logn & 255] = bus_addr;
                lg_u[logn & 255]    = bus_ustb;
                lg_l[logn & 255]    = bus_lstb;
                lg_we[logn & 255]   = bus_we;
                lg_wd[logn & 255]   = bus_wdata;
                logn++;
                wcnt = 0;
            end else begin
                bus_ack = 1'b0;
                wcnt++;
            end
        end else begin
            bus_ack = 1'b0;
            wcnt    = 0;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // results of the last transaction
    int          r_base, r_n, r_cyc;
    logic        r_err;
    logic [31:0] r_data;
    logic        r_early;

    task automatic run(input logic [AW-1:0] a, input logic [1:0] sz,
                       input logic we, input logic [31:0] wd);
        int cbase;
        r_base = logn;
        cbase  = cyc_cnt;
        r_early = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = we; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200 && !rsp_valid; i++) begin
            if (req_ready) r_early = 1'b1;
            @(negedge clk);
        end
        r_err  = rsp_err;
        r_data = rsp_rdata;
        r_n    = logn - r_base;
        r_cyc  = cyc_cnt - cbase;
        chk("R8", "rsp_valid seen", 32'(rsp_valid), 32'd1);
        chk("R8", "ready low in flight", 32'(r_early), 32'd0);
        @(negedge clk);
        chk("R8", "ready after rsp", 32'(req_ready), 32'd1);
    endtask

    task automatic t_reset();
        chk("R9", "ready", 32'(req_ready), 32'd1);
        chk("R9", "cyc/strobes/rsp", {29'd0, bus_cyc, bus_ustb | bus_lstb, rsp_valid}, 32'd0);
    endtask

    task automatic t_byte_even();
        ws = 0;
        run(24'h000104, 2'b00, 1'b0, 32'h0);
        chk("R1", "cycles", 32'(r_n), 32'd1);
        chk("R1", "strobes u,l", {30'd0, lg_u[r_base & 255], lg_l[r_base & 255]}, 32'd2);
        chk("R1", "rdata", r_data, {24'd0, mem_rd(24'h000104)[15:8]});
        chk("R10", "addr", 32'(lg_addr[r_base & 255]), 32'h104);
        run(24'h000200, 2'b00, 1'b1, 32'h0000_00AB);
        chk("R1", "write lane", 32'(lg_wd[r_base & 255][15:8]), 32'hAB);
        chk("R1", "write dir/strobes", {29'd0, lg_we[r_base & 255], lg_u[r_base & 255], lg_l[r_base & 255]}, 32'd6);
    endtask

    task automatic t_byte_odd();
        ws = 1;
        run(24'h000105, 2'b00, 1'b0, 32'h0);
        chk("R2", "err", 32'(r_err), 32'd0);
        chk("R2", "strobes u,l", {30'd0, lg_u[r_base & 255], lg_l[r_base & 255]}, 32'd1);
        chk("R2", "rdata", r_data, {24'd0, mem_rd(24'h000104)[7:0]});
        chk("R10", "addr even", 32'(lg_addr[r_base & 255]), 32'h104);
        run(24'h000201, 2'b00, 1'b1, 32'h0000_0037);
        chk("R2", "write lane", 32'(lg_wd[r_base & 255][7:0]), 32'h37);
    endtask

    task automatic t_word();
        ws = 3;
        run(24'h000300, 2'b01, 1'b0, 32'h0);
        chk("R3", "cycles", 32'(r_n), 32'd1);
        chk("R3", "strobes", {30'd0, lg_u[r_base & 255], lg_l[r_base & 255]}, 32'd3);
        chk("R3", "rdata", r_data, {16'd0, mem_rd(24'h000300)});
        chk("R7", "cycle length with 3 waits", 32'(r_cyc), 32'd4);
        ws = 0;
        run(24'h000302, 2'b01, 1'b1, 32'h1234_BEEF);
        chk("R3", "wdata", 32'(lg_wd[r_base & 255]), 32'hBEEF);
    endtask

    task automatic t_long();
        ws = 1;
        run(24'h000400, 2'b10, 1'b0, 32'h0);
        chk("R4", "cycles", 32'(r_n), 32'd2);
        chk("R4", "first addr", 32'(lg_addr[r_base & 255]), 32'h400);
        chk("R4", "second addr", 32'(lg_addr[(r_base + 1) & 255]), 32'h402);
        chk("R4", "rdata", r_data, {mem_rd(24'h000400), mem_rd(24'h000402)});
        chk("R7", "two cycles with 1 wait", 32'(r_cyc), 32'd4);
        ws = 0;
        run(24'hFFFFFC, 2'b10, 1'b1, 32'hDEAD_BEEF);
        chk("R4", "write hi first", 32'(lg_wd[r_base & 255]), 32'hDEAD);
        chk("R4", "write lo second", 32'(lg_wd[(r_base + 1) & 255]), 32'hBEEF);
        chk("R4", "write second addr", 32'(lg_addr[(r_base + 1) & 255]), 32'hFFFFFE);
    endtask

    task automatic t_misaligned();
        run(24'h000301, 2'b01, 1'b0, 32'h0);
        chk("R5", "word odd err", 32'(r_err), 32'd1);
        chk("R5", "word odd no cycle", 32'(r_cyc), 32'd0);
        chk("R5", "word odd rdata", r_data, 32'd0);
        run(24'h000403, 2'b10, 1'b1, 32'h1111_2222);
        chk("R5", "long odd err", 32'(r_err), 32'd1);
        chk("R5", "long odd no cycle", 32'(r_cyc), 32'd0);
    endtask

    task automatic t_reserved();
        run(24'h000500, 2'b11, 1'b0, 32'h0);
        chk("R6", "err", 32'(r_err), 32'd1);
        chk("R6", "no cycle", 32'(r_cyc), 32'd0);
        run(24'h000500, 2'b01, 1'b0, 32'h0);
        chk("R6", "next request clean", 32'(r_err), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_even();
        t_byte_odd();
        t_word();
        t_long();
        t_misaligned();
        t_reserved();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule